// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This block is a 16-bit counter that advances on every system clock and never stops. Around it sit a capture register and a compare register, both byte-addressable through a small register bus. The capture register stores the count when a chosen edge arrives on an external input. The compare register raises a flag when the count reaches its value, and it can drive a programmed level onto an output pin.

A combined control/status byte holds three event flags: overflow, compare and capture. It also holds one enable per flag, the capture edge select and the output level. One interrupt line is the OR of the enabled flags. A flag is cleared by a two-step handshake: first a status read, then an access to the data register that belongs to that flag. The counter can be read as two bytes without tearing, and the compare register takes a new value only when its low byte is written.

Top module: `tmr_capcmp`

## Requirements
- R1: The counter is 0 after reset and increments by one on every clock, wrapping from 0xFFFF to 0. Bus writes to the count addresses have no effect.
- R2: On the clock edge where the count wraps to 0, the overflow flag (status bit 5) is set.
- R3: Control bit 1 selects the capture edge (1 = rising, 0 = falling). The input passes through SYNC_STAGES flops. A pin change made while the count is c stores c+SYNC_STAGES in the capture register and sets status bit 7. An edge of the other polarity stores nothing.
- R4: One clock after a cycle in which the count equals the compare value, status bit 6 is set. If cmp_drive_en is high, cmp_pin takes the value of control bit 0; otherwise cmp_pin holds. After reset the compare value is 0xFFFF and cmp_pin is 0.
- R5: A write to compare-high only buffers the byte. A write to compare-low loads {buffer, byte} into the compare register.
- R6: In the cycle right after a compare-low write, a match is ignored.
- R7: A count-high read latches the low byte of the count. A later count-low read returns that latched byte, so the two reads form the 16-bit value at the time of the high read.
- R8: A status read while a flag is set arms that flag. The next matching access clears it: count-high read for overflow, capture-high read for capture, compare-low write for compare. Without the arming read, that access leaves the flag set.
- R9: irq is high exactly when some flag is set and its enable is set: bit 4 for capture, bit 3 for compare, bit 2 for overflow.
- R10: Address map: 0 control/status (bits 7..5 flags, read-only; bits 4..0 control, writable), 1 count high, 2 count low, 3 compare high, 4 compare low, 5 capture high, 6 capture low, 7 reads 0. Read data is combinational from the current state; all side effects occur at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_drive_en | input | 1 | Pin is configured as output for compare level |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Combined interrupt |

## Verification
The bench keeps its own count, stepped on every clock edge after reset. Each check therefore knows the exact count, and so the exact cycle, at which a result is due. A compare flag is expected one edge after the count equals the compare value: it is checked as still clear at that count and as set one cycle later. A capture result is expected SYNC_STAGES+1 edges after the pin change, and the stored value must be the count at the change plus SYNC_STAGES. Overflow is sampled at count 0xFFFF, where it must still be clear, and again at 0, where it must be set. All inputs change on falling edges and outputs are sampled one time unit later, so each sample sees a settled state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register addresses
   localparam int unsigned ADR_CSR    = 0;
   localparam int unsigned ADR_CNT_HI = 1;
   localparam int unsigned ADR_CNT_LO = 2;
   localparam int unsigned ADR_CMP_HI = 3;
   localparam int unsigned ADR_CMP_LO = 4;
   localparam int unsigned ADR_CAP_HI = 5;
   localparam int unsigned ADR_CAP_LO = 6;
   // status/control bit positions
   localparam int unsigned B_LEVEL  = 0;
   localparam int unsigned B_EDGE   = 1;
   localparam int unsigned B_OVF_EN = 2;
   localparam int unsigned B_OCF_EN = 3;
   localparam int unsigned B_ICF_EN = 4;
   localparam int unsigned B_OVF    = 5;
   localparam int unsigned B_OCF    = 6;
   localparam int unsigned B_ICF    = 7;
   localparam int unsigned CTL_W    = 5;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic rise_sel,
   output logic edge_pulse
);
   localparam int MSB = STAGES - 1;

   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[MSB];

   assign edge_pulse = rise_sel ? (chain[MSB] & ~prev) : (~chain[MSB] & prev);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_rd,
   output logic [CNT_W-1:0]  cnt,
   output logic [BYTE_W-1:0] lo_hold,
   output logic              wrap
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     lo_hold <= '0;
      else if (hi_rd) lo_hold <= cnt[BYTE_W-1:0];

   assign wrap = &cnt;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic arm_req,
   input  logic clr_req,
   output logic flag
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  flag <= 1'b0;
      else if (set)                flag <= 1'b1;
      else if (clr_req && armed)   flag <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  armed <= 1'b0;
      else if (clr_req)            armed <= 1'b0;
      else if (arm_req && flag)    armed <= 1'b1;
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              cap_in,
   input  logic              cmp_drive_en,
   output logic              cmp_pin,
   output logic              irq
);
   localparam logic [CNT_W-1:0] CMP_RST = '1;

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("tmr_capcmp: CNT_W must be two bytes wide");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("tmr_capcmp: status layout needs 8-bit bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_capcmp: at least two synchroniser stages");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("tmr_capcmp: address needs three bits");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   logic [CTL_W-1:0]  ctrl;
   logic [CNT_W-1:0]  cnt, cmp_q, cap_q;
   logic [BYTE_W-1:0] cnt_lo_hold, cmp_hi_buf;
   logic              wrap, cap_edge, match, commit, cmp_blk;
   logic              flag_ovf, flag_ocf, flag_icf;
   logic              rd_csr, rd_cnt_hi, rd_cap_hi;

   assign rd_csr    = bus_rd && hit(bus_addr, ADR_CSR);
   assign rd_cnt_hi = bus_rd && hit(bus_addr, ADR_CNT_HI);
   assign rd_cap_hi = bus_rd && hit(bus_addr, ADR_CAP_HI);
   assign commit    = bus_wr && hit(bus_addr, ADR_CMP_LO);

   tmr_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hi_rd(rd_cnt_hi),
      .cnt(cnt), .lo_hold(cnt_lo_hold), .wrap(wrap)
   );

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in),
      .rise_sel(ctrl[B_EDGE]), .edge_pulse(cap_edge)
   );

   // control bits
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                ctrl <= '0;
      else if (bus_wr && hit(bus_addr, ADR_CSR)) ctrl <= bus_wdata[CTL_W-1:0];

   // compare register with high-byte staging
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cmp_hi_buf <= CMP_RST[CNT_W-1:BYTE_W];
         cmp_q      <= CMP_RST;
         cmp_blk    <= 1'b0;
      end else begin
         if (bus_wr && hit(bus_addr, ADR_CMP_HI)) cmp_hi_buf <= bus_wdata;
         if (commit) cmp_q <= {cmp_hi_buf, bus_wdata};
         cmp_blk <= commit;
      end

   assign match = (cnt == cmp_q) && !cmp_blk;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     cmp_pin <= 1'b0;
      else if (match && cmp_drive_en) cmp_pin <= ctrl[B_LEVEL];

   // capture register
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        cap_q <= '0;
      else if (cap_edge) cap_q <= cnt;

   tmr_flag u_ovf (.clk(clk), .rst_n(rst_n), .set(wrap),     .arm_req(rd_csr),
                   .clr_req(rd_cnt_hi), .flag(flag_ovf));
   tmr_flag u_ocf (.clk(clk), .rst_n(rst_n), .set(match),    .arm_req(rd_csr),
                   .clr_req(commit),    .flag(flag_ocf));
   tmr_flag u_icf (.clk(clk), .rst_n(rst_n), .set(cap_edge), .arm_req(rd_csr),
                   .clr_req(rd_cap_hi), .flag(flag_icf));

   assign irq = (flag_ovf & ctrl[B_OVF_EN]) | (flag_ocf & ctrl[B_OCF_EN])
              | (flag_icf & ctrl[B_ICF_EN]);

   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, ADR_CSR)) begin
         bus_rdata[CTL_W-1:0] = ctrl;
         bus_rdata[B_OVF]     = flag_ovf;
         bus_rdata[B_OCF]     = flag_ocf;
         bus_rdata[B_ICF]     = flag_icf;
      end else if (hit(bus_addr, ADR_CNT_HI)) bus_rdata = cnt[CNT_W-1:BYTE_W];
      else if (hit(bus_addr, ADR_CNT_LO))     bus_rdata = cnt_lo_hold;
      else if (hit(bus_addr, ADR_CMP_HI))     bus_rdata = cmp_q[CNT_W-1:BYTE_W];
      else if (hit(bus_addr, ADR_CMP_LO))     bus_rdata = cmp_q[BYTE_W-1:0];
      else if (hit(bus_addr, ADR_CAP_HI))     bus_rdata = cap_q[CNT_W-1:BYTE_W];
      else if (hit(bus_addr, ADR_CAP_LO))     bus_rdata = cap_q[BYTE_W-1:0];
   end
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp_q,
   input logic [CNT_W-1:0]  cap_q,
   input logic [BYTE_W-1:0] cmp_hi_buf,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic              commit,
   input logic              cmp_blk,
   input logic              flag_ovf,
   input logic              flag_ocf,
   input logic              flag_icf,
   input logic              irq
);
   logic live;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> cnt == $past(cnt) + 1'b1);

   p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $rose(flag_ovf)) |-> cnt == '0);

   p_capture_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $rose(flag_icf)) |-> cap_q == $past(cnt));

   p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(commit)) |-> cmp_q == {$past(cmp_hi_buf), $past(bus_wdata)});

   p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (live && cmp_blk) |=> !$rose(flag_ocf));

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_ovf || flag_ocf || flag_icf) |-> !irq);
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_q(cmp_q), .cap_q(cap_q),
   .cmp_hi_buf(cmp_hi_buf), .bus_wdata(bus_wdata), .commit(commit),
   .cmp_blk(cmp_blk), .flag_ovf(flag_ovf), .flag_ocf(flag_ocf),
   .flag_icf(flag_icf), .irq(irq)
);

// File: tb/tmr_capcmp_bench.sv
module tmr_capcmp_bench;
   localparam int SYNC = 2;
   localparam logic [2:0] A_CSR = 3'd0, A_CNTH = 3'd1, A_CNTL = 3'd2, A_CMPH = 3'd3,
                          A_CMPL = 3'd4, A_CAPH = 3'd5, A_CAPL = 3'd6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_rd = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic cap_in = 1'b0, cmp_drive_en = 1'b1, cmp_pin, irq;
   logic [15:0] ref_cnt;
   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tmr_capcmp #(.SYNC_STAGES(SYNC)) u_tmr_capcmp (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_in(cap_in), .cmp_drive_en(cmp_drive_en), .cmp_pin(cmp_pin), .irq(irq)
   );

   // bench reference count: zero in reset, +1 per edge afterwards
   always @(posedge clk or negedge rst_n)
      if (!rst_n) ref_cnt <= '0;
      else        ref_cnt <= ref_cnt + 16'd1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // all bus tasks start and end on a falling edge
   task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [15:0] snap);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata; snap = ref_cnt;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      #(150000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      logic [7:0] d, h, l;
      logic [15:0] s, s2, r, tgt, v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset state
      rd(A_CSR, d, s);  check("R10 status after reset", d, 8'h00);
      rd(A_CMPH, h, s); rd(A_CMPL, l, s);
      check("R4 compare reset value", {h, l}, 16'hFFFF);
      rd(A_CAPH, h, s); rd(A_CAPL, l, s);
      check("R3 capture reset value", {h, l}, 16'h0000);
      check("R9 irq after reset", irq, 0);
      check("R4 pin after reset", cmp_pin, 0);

      // atomic count read with several gaps (R7), writes ignored (R1)
      for (int k = 0; k < 6; k++) begin
         rd(A_CNTH, h, s); idle(k * 37); rd(A_CNTL, l, s2);
         check("R7 latched 16-bit read", {h, l}, s);
      end
      wr(A_CNTH, 8'h12); wr(A_CNTL, 8'h34);
      rd(A_CNTH, h, s); rd(A_CNTL, l, s2);
      check("R1 count unaffected by writes", {h, l}, s);

      // compare sweep (R4)
      for (int i = 0; i < 6; i++) begin
         logic lvl, exp_pin;
         lvl = i[0];
         exp_pin = (i == 5) ? 1'b0 : lvl;
         cmp_drive_en = (i != 5);
         wr(A_CSR, 8'h08 | {7'd0, lvl});
         rd(A_CSR, d, s);
         tgt = ref_cnt + 16'(12 + i * 7);
         wr(A_CMPH, tgt[15:8]); wr(A_CMPL, tgt[7:0]);
         while (ref_cnt != tgt) @(negedge clk);
         rd(A_CSR, d, s);
         check("R4 flag not set before match", d[6], 0);
         check("R4 irq after match", irq, 1);
         check("R4 pin level after match", cmp_pin, exp_pin);
         rd(A_CSR, d, s);
         check("R4 status bit 6 after match", d[6], 1);
      end
      cmp_drive_en = 1'b1;

      // staged compare write (R5)
      rd(A_CMPH, h, s); rd(A_CMPL, l, s); v = {h, l};
      wr(A_CMPH, 8'hAB);
      rd(A_CMPH, h, s); rd(A_CMPL, l, s);
      check("R5 high write alone no effect", {h, l}, v);
      wr(A_CMPL, 8'hCD);
      rd(A_CMPH, h, s); rd(A_CMPL, l, s);
      check("R5 low write commits", {h, l}, 16'hABCD);

      // match in blanked cycle is ignored (R6)
      rd(A_CSR, d, s);
      r = ref_cnt; v = r + 16'd2;
      wr(A_CMPH, v[15:8]); wr(A_CMPL, v[7:0]);
      idle(2);
      rd(A_CSR, d, s);
      check("R6 match right after write ignored", d[6], 0);
      r = ref_cnt; v = r + 16'd3;
      wr(A_CMPH, v[15:8]); wr(A_CMPL, v[7:0]);
      idle(2);
      rd(A_CSR, d, s);
      check("R6 match one cycle later taken", d[6], 1);

      // compare flag clear handshake (R8), observed through irq
      wr(A_CSR, 8'h08);
      rd(A_CSR, d, s);
      v = ref_cnt + 16'd10;
      wr(A_CMPH, v[15:8]); wr(A_CMPL, v[7:0]);
      check("R8 armed compare write clears", irq, 0);
      while (ref_cnt != v + 16'd1) @(negedge clk);
      check("R4 flag set again", irq, 1);
      v = ref_cnt + 16'h4000;
      wr(A_CMPH, v[15:8]); wr(A_CMPL, v[7:0]);
      check("R8 unarmed write keeps flag", irq, 1);
      rd(A_CSR, d, s);
      wr(A_CMPL, v[7:0]);
      check("R8 status read then write clears", irq, 0);

      // capture sweep over edge select and pin direction (R3)
      for (int rnd = 0; rnd < 2; rnd++)
         for (int sel = 0; sel < 2; sel++)
            for (int rise = 0; rise < 2; rise++) begin
               logic [15:0] prev, cv;
               bit hitx;
               hitx = (sel == rise);
               cap_in = (rise == 0);
               idle(SYNC + 3);
               rd(A_CSR, d, s); rd(A_CAPH, h, s);
               rd(A_CAPH, h, s); rd(A_CAPL, l, s); prev = {h, l};
               wr(A_CSR, 8'h10 | 8'(sel << 1));
               idle(rnd * 5);
               r = ref_cnt;
               cap_in = (rise == 1);
               idle(SYNC + 1);
               check("R3 irq on selected edge", irq, hitx);
               rd(A_CAPH, h, s); rd(A_CAPL, l, s); cv = {h, l};
               rd(A_CSR, d, s);
               check("R3 capture flag", d[7], hitx);
               check("R3 captured value", cv, hitx ? r + 16'(SYNC) : prev);
            end
      rd(A_CSR, d, s); rd(A_CAPH, h, s);
      rd(A_CSR, d, s);
      check("R8 capture flag cleared", d[7], 0);

      // overflow (R2) and irq gating (R9)
      wr(A_CSR, 8'h04);
      while (ref_cnt != 16'hFFFF) @(negedge clk);
      rd(A_CSR, d, s);
      check("R2 no flag before wrap", d[5], 0);
      check("R1 count wrapped to zero", ref_cnt, 0);
      check("R9 irq with overflow enabled", irq, 1);
      rd(A_CSR, d, s);
      check("R2 status bit 5 after wrap", d[5], 1);
      wr(A_CSR, 8'h00);
      check("R9 irq gated off", irq, 0);
      rd(A_CNTH, h, s);
      rd(A_CSR, d, s);
      check("R8 overflow cleared by count read", d[5], 0);

      finish_run();
   end
endmodule